// File: doc/BRIEF.md
# Byte-Load Instruction Sequencer

This block runs the byte-move subset of an 8-bit accumulator processor. It fetches instruction bytes through a byte-wide memory port and executes five kinds of move. It copies one register into another and loads a register from an inline constant. It moves a byte between a register and the memory byte addressed by the H:L pair. It stores an inline constant at H:L. With a one-byte prefix, it moves a byte between a register and the memory byte addressed by an external 16-bit index value plus a signed displacement. The register file holds seven bytes: A, B, C, D, E, H and L.

Each clock is one processor clock state. Instructions are built from machine cycles of 3, 4 or 5 states, and the block keeps the exact length of every instruction. When an instruction finishes, it reports how many states it took. A halt opcode stops the fetch loop. Any opcode outside the supported set also stops the block and raises a sticky illegal flag. Both conditions last until reset. The two index values are inputs, driven by the surrounding core. A debug port reads any register.

Top module: `ld8_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0x0000, all seven registers become 0x00, `halted`, `illegal` and `instr_done` become 0, and no memory write is issued.
- R2: The register field is 3 bits wide, with B=000, C=001, D=010, E=011, H=100, L=101 and A=111; code 110 means memory. Opcode 01 ddd sss, with neither field equal to 110, copies register sss into register ddd. It takes 4 states, and all other registers are left unchanged.
- R3: Opcode 00 ddd 110 (ddd not 110) is followed by one data byte, which is written to register ddd. It takes 7 states.
- R4: Opcode 01 ddd 110 (ddd not 110) reads the byte at address {H,L} into register ddd. It takes 7 states.
- R5: Opcode 01 110 sss (sss not 110) writes register sss to address {H,L}. It takes 7 states, and `mem_wr` is high for exactly one clock, in the last state, never together with `mem_rd`.
- R6: Opcode 0x36 followed by a byte n writes n to address {H,L}. It takes 10 states.
- R7: Prefix 0xDD selects `ix_val` and prefix 0xFD selects `iy_val`. The following opcode must be 01 ddd 110 (load) or 01 110 sss (store), followed by a displacement byte. The address is the selected base plus the displacement as a signed two's-complement byte. Each such instruction takes 19 states.
- R8: The indexed address wraps modulo 65536.
- R9: `pc` increases by one for each byte fetched (prefix, opcode, constant or displacement) and is otherwise unchanged.
- R10: Opcode 0x76 (unprefixed) is a halt. After its 4-state fetch, `halted` is 1, `pc` no longer changes, and neither `mem_rd` nor `mem_wr` is asserted until reset.
- R11: Any other opcode stops the block with `illegal` held at 1 until reset. This includes an unsupported opcode after a prefix, a second prefix, and 0x76 after a prefix. No `instr_done` pulse is given for it.
- R12: Each completed instruction gives exactly one one-clock `instr_done` pulse, in the clock after its last state, with `instr_states` equal to its total state count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one processor clock state |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | High during every state of a read machine cycle |
| mem_wr | output | 1 | Write strobe, last state of a write machine cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same clock as `mem_addr` |
| ix_val | input | 16 | Base selected by the 0xDD prefix |
| iy_val | input | 16 | Base selected by the 0xFD prefix |
| pc | output | 16 | Program counter |
| instr_done | output | 1 | One-clock pulse after an instruction ends |
| instr_states | output | 5 | State count of the instruction just ended |
| halted | output | 1 | Halt executed |
| illegal | output | 1 | Unsupported opcode seen |
| dbg_sel | input | 3 | Debug register select, same coding as R2 |
| dbg_data | output | 8 | Debug register value (0x00 for code 110) |

## Verification
The checker relies on two properties of the memory. Read data must be settled combinationally within the clock in which the address is presented. Writes must complete at the clock edge at which the strobe is seen. The bench models the memory as a plain array with exactly that timing. The checker also assumes that `ix_val` and `iy_val` do not change during an indexed instruction. The bench sets them only while reset is held, before each program starts.

// File: rtl/ld8_pkg.sv
package ld8_pkg;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 3;
    localparam int STATE_W = 5;
    localparam int TCNT_W  = 3;

    localparam logic [DATA_W-1:0] PFX_X    = 8'hDD;
    localparam logic [DATA_W-1:0] PFX_Y    = 8'hFD;
    localparam logic [DATA_W-1:0] OP_HALT  = 8'h76;
    localparam logic [DATA_W-1:0] OP_STIMM = 8'h36;

    localparam logic [SEL_W-1:0] CODE_MEM = 3'b110;
    localparam logic [SEL_W-1:0] CODE_H   = 3'b100;
    localparam logic [SEL_W-1:0] CODE_L   = 3'b101;

    typedef enum logic [2:0] {
        OPK_COPY,
        OPK_IMM,
        OPK_LOADM,
        OPK_STOREM,
        OPK_STOREI,
        OPK_HALT,
        OPK_PREFIX,
        OPK_BAD
    } opk_t;

    typedef struct packed {
        opk_t             kind;
        logic [SEL_W-1:0] dst;
        logic [SEL_W-1:0] src;
    } dec_t;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_OPC2,
        PH_IMM,
        PH_DISP,
        PH_ADD,
        PH_MRD,
        PH_MWR,
        PH_STOP
    } phase_t;

    typedef enum logic [1:0] {
        BASE_HL,
        BASE_X,
        BASE_Y
    } base_t;

    // index of the last clock state of each machine-cycle kind
    function automatic logic [TCNT_W-1:0] phase_last(phase_t p);
        case (p)
            PH_OPC, PH_OPC2:       return 3'd3;
            PH_IMM, PH_DISP:       return 3'd2;
            PH_ADD:                return 3'd4;
            PH_MRD, PH_MWR:        return 3'd2;
            default:               return 3'd0;
        endcase
    endfunction

    function automatic dec_t classify(logic [DATA_W-1:0] op, logic indexed);
        dec_t d;
        d.dst  = op[5:3];
        d.src  = op[2:0];
        d.kind = OPK_BAD;
        if (!indexed) begin
            if (op == PFX_X || op == PFX_Y)       d.kind = OPK_PREFIX;
            else if (op == OP_HALT)               d.kind = OPK_HALT;
            else if (op == OP_STIMM)              d.kind = OPK_STOREI;
            else if (op[7:6] == 2'b01) begin
                if (op[5:3] == CODE_MEM)          d.kind = OPK_STOREM;
                else if (op[2:0] == CODE_MEM)     d.kind = OPK_LOADM;
                else                              d.kind = OPK_COPY;
            end
            else if (op[7:6] == 2'b00 && op[2:0] == CODE_MEM)
                                                  d.kind = OPK_IMM;
        end else if (op[7:6] == 2'b01 && op != OP_HALT) begin
            if (op[5:3] == CODE_MEM)              d.kind = OPK_STOREM;
            else if (op[2:0] == CODE_MEM)         d.kind = OPK_LOADM;
        end
        return d;
    endfunction

endpackage

// File: rtl/ld8_regfile.sv
module ld8_regfile
    import ld8_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int SELW = SEL_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SELW-1:0] waddr,
    input  logic [DW-1:0]   wdata,
    input  logic [SELW-1:0] ra_sel,
    output logic [DW-1:0]   ra_data,
    output logic [2*DW-1:0] hl,
    input  logic [SELW-1:0] dbg_sel,
    output logic [DW-1:0]   dbg_data
);
    localparam int NSLOT = 1 << SELW;

    logic [DW-1:0] slot_q [NSLOT];

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            if (g == int'(CODE_MEM)) begin : g_hole
                assign slot_q[g] = '0;
            end else begin : g_reg
                always_ff @(posedge clk) begin
                    if (rst)
                        slot_q[g] <= '0;
                    else if (we && waddr == SELW'(g))
                        slot_q[g] <= wdata;
                end
            end
        end
    endgenerate

    assign ra_data  = slot_q[ra_sel];
    assign dbg_data = slot_q[dbg_sel];
    assign hl       = {slot_q[CODE_H], slot_q[CODE_L]};
endmodule

// File: rtl/ld8_decode.sv
module ld8_decode
    import ld8_pkg::*;
(
    input  logic [DATA_W-1:0] op,
    input  logic              indexed,
    output dec_t              dec
);
    always_comb dec = classify(op, indexed);
endmodule

// File: rtl/ld8_addrgen.sv
module ld8_addrgen #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] ea
);
    localparam int EXT_W = AW - DW;

    // signed displacement, sum truncated to AW bits
    assign ea = base + {{EXT_W{disp[DW-1]}}, disp};
endmodule

// File: rtl/ld8_sequencer.sv
module ld8_sequencer
    import ld8_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [ADDR_W-1:0]  ix_val,
    input  logic [ADDR_W-1:0]  iy_val,
    output logic [ADDR_W-1:0]  pc,
    output logic               instr_done,
    output logic [STATE_W-1:0] instr_states,
    output logic               halted,
    output logic               illegal,
    input  logic [SEL_W-1:0]   dbg_sel,
    output logic [DATA_W-1:0]  dbg_data
);
    phase_t              phase_q;
    logic [TCNT_W-1:0]   tcnt_q;
    logic [ADDR_W-1:0]   pc_q;
    opk_t                kind_q;
    logic [SEL_W-1:0]    dst_q;
    logic [SEL_W-1:0]    src_q;
    base_t               base_q;
    logic [DATA_W-1:0]   imm_q;
    logic [ADDR_W-1:0]   ea_q;
    logic [STATE_W-1:0]  scnt_q;
    logic                done_q;
    logic [STATE_W-1:0]  dstates_q;
    logic                halt_q;
    logic                bad_q;

    dec_t                dec;
    logic                last;
    logic                finish;
    logic                rf_we;
    logic [SEL_W-1:0]    rf_waddr;
    logic [DATA_W-1:0]   rf_wdata;
    logic [SEL_W-1:0]    ra_sel;
    logic [DATA_W-1:0]   ra_data;
    logic [ADDR_W-1:0]   hl;
    logic [ADDR_W-1:0]   base_val;
    logic [ADDR_W-1:0]   ea_idx;

    ld8_decode u_dec (
        .op      (mem_rdata),
        .indexed (phase_q == PH_OPC2),
        .dec     (dec)
    );

    ld8_regfile #(.DW(DATA_W), .SELW(SEL_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .ra_sel   (ra_sel),
        .ra_data  (ra_data),
        .hl       (hl),
        .dbg_sel  (dbg_sel),
        .dbg_data (dbg_data)
    );

    always_comb begin
        case (base_q)
            BASE_X:  base_val = ix_val;
            BASE_Y:  base_val = iy_val;
            default: base_val = hl;
        endcase
    end

    ld8_addrgen #(.AW(ADDR_W), .DW(DATA_W)) u_ag (
        .base (base_val),
        .disp (mem_rdata),
        .ea   (ea_idx)
    );

    assign last   = (tcnt_q == phase_last(phase_q));
    assign ra_sel = (phase_q == PH_OPC) ? dec.src : src_q;

    always_comb begin
        finish = 1'b0;
        if (last) begin
            case (phase_q)
                PH_OPC:         finish = (dec.kind == OPK_COPY);
                PH_IMM:         finish = (kind_q == OPK_IMM);
                PH_MRD, PH_MWR: finish = 1'b1;
                default:        finish = 1'b0;
            endcase
        end
    end

    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = dst_q;
        rf_wdata = mem_rdata;
        if (last) begin
            case (phase_q)
                PH_OPC: begin
                    if (dec.kind == OPK_COPY) begin
                        rf_we    = 1'b1;
                        rf_waddr = dec.dst;
                        rf_wdata = ra_data;
                    end
                end
                PH_IMM:  rf_we = (kind_q == OPK_IMM);
                PH_MRD:  rf_we = 1'b1;
                default: rf_we = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_OPC;
            tcnt_q    <= '0;
            pc_q      <= RESET_PC;
            kind_q    <= OPK_COPY;
            dst_q     <= '0;
            src_q     <= '0;
            base_q    <= BASE_HL;
            imm_q     <= '0;
            ea_q      <= '0;
            scnt_q    <= '0;
            done_q    <= 1'b0;
            dstates_q <= '0;
            halt_q    <= 1'b0;
            bad_q     <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish)
                dstates_q <= scnt_q + 1'b1;
            if (phase_q != PH_STOP) begin
                scnt_q <= finish ? '0 : scnt_q + 1'b1;
                if (!last) begin
                    tcnt_q <= tcnt_q + 1'b1;
                end else begin
                    tcnt_q <= '0;
                    case (phase_q)
                        PH_OPC: begin
                            pc_q   <= pc_q + 1'b1;
                            dst_q  <= dec.dst;
                            src_q  <= dec.src;
                            kind_q <= dec.kind;
                            case (dec.kind)
                                OPK_COPY:   phase_q <= PH_OPC;
                                OPK_IMM,
                                OPK_STOREI: phase_q <= PH_IMM;
                                OPK_LOADM: begin
                                    ea_q    <= hl;
                                    phase_q <= PH_MRD;
                                end
                                OPK_STOREM: begin
                                    ea_q    <= hl;
                                    phase_q <= PH_MWR;
                                end
                                OPK_HALT: begin
                                    halt_q  <= 1'b1;
                                    phase_q <= PH_STOP;
                                end
                                OPK_PREFIX: begin
                                    base_q  <= (mem_rdata == PFX_Y) ? BASE_Y : BASE_X;
                                    phase_q <= PH_OPC2;
                                end
                                default: begin
                                    bad_q   <= 1'b1;
                                    phase_q <= PH_STOP;
                                end
                            endcase
                        end
                        PH_OPC2: begin
                            pc_q   <= pc_q + 1'b1;
                            dst_q  <= dec.dst;
                            src_q  <= dec.src;
                            kind_q <= dec.kind;
                            if (dec.kind == OPK_LOADM || dec.kind == OPK_STOREM) begin
                                phase_q <= PH_DISP;
                            end else begin
                                bad_q   <= 1'b1;
                                phase_q <= PH_STOP;
                            end
                        end
                        PH_IMM: begin
                            pc_q  <= pc_q + 1'b1;
                            imm_q <= mem_rdata;
                            if (kind_q == OPK_STOREI) begin
                                ea_q    <= hl;
                                phase_q <= PH_MWR;
                            end else begin
                                phase_q <= PH_OPC;
                            end
                        end
                        PH_DISP: begin
                            pc_q    <= pc_q + 1'b1;
                            ea_q    <= ea_idx;
                            phase_q <= PH_ADD;
                        end
                        PH_ADD:
                            phase_q <= (kind_q == OPK_LOADM) ? PH_MRD : PH_MWR;
                        PH_MRD, PH_MWR:
                            phase_q <= PH_OPC;
                        default:
                            phase_q <= PH_STOP;
                    endcase
                end
            end
        end
    end

    always_comb begin
        case (phase_q)
            PH_MRD, PH_MWR: mem_addr = ea_q;
            default:        mem_addr = pc_q;
        endcase
    end

    assign mem_rd = (phase_q == PH_OPC)  || (phase_q == PH_OPC2) ||
                    (phase_q == PH_IMM)  || (phase_q == PH_DISP) ||
                    (phase_q == PH_MRD);
    assign mem_wr    = (phase_q == PH_MWR) && last;
    assign mem_wdata = (kind_q == OPK_STOREI) ? imm_q : ra_data;

    assign pc           = pc_q;
    assign instr_done   = done_q;
    assign instr_states = dstates_q;
    assign halted       = halt_q;
    assign illegal      = bad_q;
endmodule

// File: rtl/ld8_sequencer_chk.sv
module ld8_sequencer_chk
    import ld8_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [ADDR_W-1:0]  pc,
    input logic               instr_done,
    input logic [STATE_W-1:0] instr_states,
    input logic               halted,
    input logic               illegal
);
    // R5
    wr_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !mem_rd);

    // R5
    store_ends_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> instr_done);

    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc == $past(pc) || pc == $past(pc) + 16'd1));

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc) && halted);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_rd && !mem_wr);

    // R11
    bad_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |=> illegal && !halted && !instr_done);

    // R12
    done_len_chk: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> (instr_states == 5'd4 || instr_states == 5'd7 ||
                        instr_states == 5'd10 || instr_states == 5'd19));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> !instr_done);
endmodule

bind ld8_sequencer ld8_sequencer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .pc           (pc),
    .instr_done   (instr_done),
    .instr_states (instr_states),
    .halted       (halted),
    .illegal      (illegal)
);

// File: tb/ld8_sequencer_bench.sv
module ld8_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] ix_val = 16'h0000;
    logic [15:0] iy_val = 16'h0000;
    logic [15:0] pc;
    logic        instr_done;
    logic [4:0]  instr_states;
    logic        halted, illegal;
    logic [2:0]  dbg_sel = 3'd0;
    logic [7:0]  dbg_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc_all = 0;
    int nlog = 0;
    int log_st [16];
    int nwr = 0;
    int rd_cnt = 0;
    logic [15:0] last_wa;
    logic [7:0]  last_wd;
    logic [7:0]  mem [1024];
    int pos = 0;

    always #10 clk = ~clk;

    ld8_sequencer u_ld8_sequencer (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ix_val(ix_val), .iy_val(iy_val), .pc(pc), .instr_done(instr_done),
        .instr_states(instr_states), .halted(halted), .illegal(illegal),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[mem_addr[9:0]] = mem_wdata;
            nwr++;
            last_wa = mem_addr;
            last_wd = mem_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst && instr_done && nlog < 16) begin
            log_st[nlog] = int'(instr_states);
            nlog++;
        end
        if (mem_rd) rd_cnt++;
    end

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 150000) begin
            n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc_all);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] code_of(input int k);
        case (k)
            0: return 3'd7;
            1: return 3'd0;
            2: return 3'd1;
            3: return 3'd2;
            4: return 3'd3;
            5: return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        pos = 0;
    endtask

    task automatic put(input logic [7:0] b);
        mem[pos] = b;
        pos++;
    endtask

    task automatic get_reg(input logic [2:0] c, output logic [7:0] v);
        dbg_sel = c;
        #1;
        v = dbg_data;
    endtask

    task automatic run_prog(output int cyc);
        @(negedge clk);
        rst = 1'b1;
        nlog = 0;
        nwr = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!halted && !illegal && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic idx_case(input string tag, input logic [7:0] pfx,
                            input logic [15:0] xv, input logic [15:0] yv,
                            input logic [7:0] d, input bit st,
                            input logic [2:0] c, input logic [7:0] v);
        logic [15:0] base;
        logic [15:0] ea;
        logic [7:0]  got;
        int          cyc;
        base = (pfx == 8'hDD) ? xv : yv;
        ea   = base + {{8{d[7]}}, d};
        ix_val = xv;
        iy_val = yv;
        clear_mem();
        if (st) begin
            put({2'b00, c, 3'b110}); put(v);
            put(pfx); put({5'b01110, c}); put(d); put(8'h76);
            run_prog(cyc);
            chk({tag, " store address"}, int'(last_wa), int'(ea));
            chk({tag, " store data"}, int'(last_wd), int'(v));
            chk({tag, " write count"}, nwr, 1);
            chk({tag, " states"}, log_st[1], 19);
            chk({tag, " total states"}, cyc, 7 + 19 + 4);
            chk({tag, " R9 pc"}, int'(pc), 6);
        end else begin
            mem[ea[9:0]] = v;
            put(pfx); put({2'b01, c, 3'b110}); put(d); put(8'h76);
            run_prog(cyc);
            get_reg(c, got);
            chk({tag, " load value"}, int'(got), int'(v));
            chk({tag, " states"}, log_st[0], 19);
            chk({tag, " total states"}, cyc, 19 + 4);
            chk({tag, " R12 pulse count"}, nlog, 1);
        end
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] exp_v;
        int         cyc;
        int         rd0;
        logic [15:0] pc0;

        // R1: reset state
        clear_mem();
        repeat (2) @(negedge clk);
        chk("R1 pc", int'(pc), 0);
        chk("R1 halted", int'(halted), 0);
        chk("R1 illegal", int'(illegal), 0);
        chk("R1 done", int'(instr_done), 0);
        chk("R1 write", int'(mem_wr), 0);
        for (int k = 0; k < 7; k++) begin
            get_reg(code_of(k), got);
            chk("R1 register", int'(got), 0);
        end

        // R3: immediate load of every register
        clear_mem();
        for (int k = 0; k < 7; k++) begin
            put({2'b00, code_of(k), 3'b110});
            put(8'(8'h10 + 8'h13 * k));
        end
        put(8'h76);
        run_prog(cyc);
        for (int k = 0; k < 7; k++) begin
            get_reg(code_of(k), got);
            chk("R3 value", int'(got), int'(8'(8'h10 + 8'h13 * k)));
            chk("R3 states", log_st[k], 7);
        end
        chk("R3 total states", cyc, 7 * 7 + 4);
        chk("R12 pulse count", nlog, 7);
        chk("R9 pc after immediates", int'(pc), 15);

        // R10: halt stays quiet and frozen
        pc0 = pc;
        rd0 = rd_cnt;
        repeat (20) @(negedge clk);
        chk("R10 halted", int'(halted), 1);
        chk("R10 pc frozen", int'(pc), int'(pc0));
        chk("R10 no reads", rd_cnt - rd0, 0);
        chk("R10 no writes", nwr, 0);

        // R2: all 49 register copies
        for (int di = 0; di < 7; di++) begin
            for (int si = 0; si < 7; si++) begin
                clear_mem();
                for (int k = 0; k < 7; k++) begin
                    put({2'b00, code_of(k), 3'b110});
                    put({5'b10100, code_of(k)});
                end
                put({2'b01, code_of(di), code_of(si)});
                put(8'h76);
                run_prog(cyc);
                for (int k = 0; k < 7; k++) begin
                    get_reg(code_of(k), got);
                    exp_v = (k == di) ? {5'b10100, code_of(si)} : {5'b10100, code_of(k)};
                    chk("R2 copy result", int'(got), int'(exp_v));
                end
                chk("R2 states", log_st[7], 4);
                chk("R2 total states", cyc, 7 * 7 + 4 + 4);
            end
        end

        // R4: load from {H,L}
        for (int k = 0; k < 7; k++) begin
            clear_mem();
            mem[10'h320] = 8'hC0 + 8'(k);
            put(8'h26); put(8'h03);
            put(8'h2E); put(8'h20);
            put({2'b01, code_of(k), 3'b110});
            put(8'h76);
            run_prog(cyc);
            get_reg(code_of(k), got);
            chk("R4 load value", int'(got), int'(8'hC0 + 8'(k)));
            chk("R4 states", log_st[2], 7);
            chk("R4 total states", cyc, 7 + 7 + 7 + 4);
        end

        // R5: store to {H,L}
        for (int k = 0; k < 7; k++) begin
            clear_mem();
            put({2'b00, code_of(k), 3'b110}); put(8'h50 + 8'(k));
            put(8'h26); put(8'h03);
            put(8'h2E); put(8'h44);
            put({5'b01110, code_of(k)});
            put(8'h76);
            run_prog(cyc);
            exp_v = (code_of(k) == 3'd4) ? 8'h03 :
                    (code_of(k) == 3'd5) ? 8'h44 : 8'h50 + 8'(k);
            chk("R5 store address", int'(last_wa), 16'h0344);
            chk("R5 store data", int'(last_wd), int'(exp_v));
            chk("R5 single strobe", nwr, 1);
            chk("R5 states", log_st[3], 7);
        end

        // R6: constant store to {H,L}
        clear_mem();
        put(8'h26); put(8'h03);
        put(8'h2E); put(8'h50);
        put(8'h36); put(8'hA7);
        put(8'h76);
        run_prog(cyc);
        chk("R6 address", int'(last_wa), 16'h0350);
        chk("R6 data", int'(last_wd), 8'hA7);
        chk("R6 states", log_st[2], 10);
        chk("R6 total states", cyc, 7 + 7 + 10 + 4);
        chk("R9 pc after constant store", int'(pc), 7);

        // R7 and R8: indexed forms
        idx_case("R7 X load +d",  8'hDD, 16'h0300, 16'h0100, 8'h05, 1'b0, 3'd0, 8'h3C);
        idx_case("R7 Y load -d",  8'hFD, 16'h0100, 16'h0310, 8'hFD, 1'b0, 3'd7, 8'h6B);
        idx_case("R7 X store -128", 8'hDD, 16'h0200, 16'h0000, 8'h80, 1'b1, 3'd3, 8'h9E);
        idx_case("R8 Y store wrap", 8'hFD, 16'h0000, 16'hFFF0, 8'h70, 1'b1, 3'd7, 8'h4D);
        idx_case("R8 X load wrap",  8'hDD, 16'h0005, 16'h0300, 8'h80, 1'b0, 3'd5, 8'hE1);

        // R11: unsupported opcodes
        clear_mem(); put(8'h00);
        run_prog(cyc);
        chk("R11 plain opcode flag", int'(illegal), 1);
        chk("R11 plain opcode pc", int'(pc), 1);
        chk("R11 no done", nlog, 0);
        clear_mem(); put(8'hDD); put(8'h36);
        run_prog(cyc);
        chk("R11 prefixed constant store", int'(illegal), 1);
        chk("R11 prefixed pc", int'(pc), 2);
        clear_mem(); put(8'hFD); put(8'h40);
        run_prog(cyc);
        chk("R11 prefixed copy", int'(illegal), 1);
        clear_mem(); put(8'hDD); put(8'hFD);
        run_prog(cyc);
        chk("R11 double prefix", int'(illegal), 1);
        clear_mem(); put(8'hDD); put(8'h76);
        run_prog(cyc);
        chk("R11 prefixed halt flag", int'(illegal), 1);
        chk("R11 prefixed halt not halted", int'(halted), 0);
        pc0 = pc;
        rd0 = rd_cnt;
        repeat (10) @(negedge clk);
        chk("R11 stopped pc", int'(pc), int'(pc0));
        chk("R11 stopped reads", rd_cnt - rd0, 0);
        chk("R11 sticky", int'(illegal), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule